// File: doc/BRIEF.md
# EEPROM page write sequencer

This block is the write engine of a byte-wide parallel EEPROM, with the storage array kept in registers. A host presents byte-load strobes, each carrying an address and a data byte. The first load of a burst fixes the page. Further loads to that page are gathered in a 64-entry staging buffer, and each one marks its slot as filled. A retriggerable quiet-time counter restarts on every accepted load. Once the counter runs out with no further load, the block starts one programming phase of fixed length. At the end of that phase every filled slot is copied into the array in the same clock edge.

A separate read port returns array contents. While a burst is open or being programmed, a read of the most recently loaded address returns a status byte instead of the stored one: bit 7 is the inverse of the loaded bit 7. A host polls that address until the true value comes back. The quiet window and the programming time are parameters counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: Synchronous active-high reset drops `busy` and discards every staged byte. Array contents survive reset, and a burst cut short by reset is never committed.
- R2: A load strobe while `busy` is low is accepted and opens a burst. `busy` is high from the clock edge that captures it.
- R3: The quiet counter restarts on every accepted load. Programming starts only after `LOAD_WIN` consecutive cycles with no accepted load. Until the commit, reads of addresses other than the poll address return the old array contents.
- R4: Programming always lasts `PROG_CYC` cycles, whether one byte or 64 were loaded. `busy` falls exactly `LOAD_WIN + PROG_CYC` edges after the edge that captured the last accepted load.
- R5: The byte offset is address bits [5:0] and the page is the address bits above bit 5. All staged bytes of the page are written to the array at the same edge.
- R6: The page is fixed by the first load of a burst. A load to another page during the open burst is ignored: its byte is not written and it does not restart the quiet counter.
- R7: Loads that arrive during the programming phase are ignored.
- R8: Offsets not loaded in a burst keep their earlier array contents. When one offset is loaded more than once, the last value is committed.
- R9: While `busy` is high, a read of the last accepted load address returns {~d[7], d[6:0]}, where d is the data of that load.
- R10: After `busy` falls, reads return the true committed data on all eight bits, and a new burst may be opened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Byte-load strobe, one cycle per byte |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_wdata | input | 8 | Data byte of the load |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational), or polling status |
| busy | output | 1 | High from a burst's first load until its commit |

## Verification
A wrong quiet counter or phase counter shows up as `busy` falling on the wrong edge. That edge is predicted to the exact cycle from the last accepted load, so a retrigger that is missed, or an ignored load that restarts the counter, is caught in the cycle it would act. A wrong page filter or bad staging flags show only after the commit: array reads then return stray or missing bytes. A wrong poll register shows in the first read issued one cycle after a load.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int OFS_W      = 6;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eepw_state_e;

    typedef struct packed {
        logic  vld;
        byte_t data;
    } slot_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic byte_t poll_byte(input byte_t d);
        return {~d[7], d[6:0]};
    endfunction

endpackage

// File: rtl/eepw_cycle_timer.sv
module eepw_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            count <= '0;
        else if (count != {CNT_W{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/eepw_page_buffer.sv
module eepw_page_buffer
    import eepw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [OFS_W-1:0]      wr_ofs,
    input  byte_t                 wr_data,
    output slot_t [PAGE_BYTES-1:0] slots
);
    for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slots[o].vld <= 1'b0;
            end else if (wr_en && wr_ofs == OFS_W'(o)) begin
                slots[o].vld  <= 1'b1;
                slots[o].data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/eepw_cell_array.sv
module eepw_cell_array
    import eepw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic [ADDR_W-OFS_W-1:0] commit_page,
    input  slot_t [PAGE_BYTES-1:0]  slots,
    input  logic [ADDR_W-1:0]       rd_addr,
    output byte_t                   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int o = 0; o < PAGE_BYTES; o++) begin
                if (slots[o].vld)
                    cells[{commit_page, OFS_W'(o)}] <= slots[o].data;
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_stb,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(max_int(LOAD_WIN, PROG_CYC) + 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(LOAD_WIN - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);

    eepw_state_e             state_q, state_d;
    logic [PAGE_W-1:0]       page_q;
    logic [ADDR_W-1:0]       last_addr_q;
    byte_t                   last_data_q;
    logic [CNT_W-1:0]        tcount;
    slot_t [PAGE_BYTES-1:0]  slots;
    byte_t                   arr_rd;
    logic                    accept, win_done, prog_done;

    // A load opens a burst when idle, or joins the open burst on its own page
    always_comb begin
        accept = 1'b0;
        if (ld_stb) begin
            if (state_q == ST_IDLE)
                accept = 1'b1;
            else if (state_q == ST_LOAD && ld_addr[ADDR_W-1:OFS_W] == page_q)
                accept = 1'b1;
        end
    end

    assign win_done  = (state_q == ST_LOAD) && !accept && (tcount == WIN_LAST);
    assign prog_done = (state_q == ST_PROG) && (tcount == PROG_LAST);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)    state_d = ST_LOAD;
            ST_LOAD: if (win_done)  state_d = ST_PROG;
            ST_PROG: if (prog_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            page_q      <= '0;
            last_addr_q <= '0;
            last_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                last_addr_q <= ld_addr;
                last_data_q <= ld_wdata;
                if (state_q == ST_IDLE)
                    page_q <= ld_addr[ADDR_W-1:OFS_W];
            end
        end
    end

    // One counter serves both the quiet window and the programming phase
    eepw_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept || win_done),
        .count   (tcount)
    );

    eepw_page_buffer u_buf (
        .clk     (clk),
        .rst     (rst),
        .clear   (prog_done),
        .wr_en   (accept),
        .wr_ofs  (ld_addr[OFS_W-1:0]),
        .wr_data (ld_wdata),
        .slots   (slots)
    );

    eepw_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk         (clk),
        .commit      (prog_done),
        .commit_page (page_q),
        .slots       (slots),
        .rd_addr     (rd_addr),
        .rd_data     (arr_rd)
    );

    assign busy    = (state_q != ST_IDLE);
    assign rd_data = (busy && rd_addr == last_addr_q) ? poll_byte(last_data_q) : arr_rd;

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
    parameter int ADDR_W   = 10,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_stb,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [7:0]        ld_wdata,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy
);
    localparam int MIN_BUSY = LOAD_WIN + PROG_CYC;

    int busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_len <= 0;
        else if (busy_len < MIN_BUSY)
            busy_len <= busy_len + 1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy);

    // R2
    open_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_stb) |=> busy);

    // R4
    min_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len >= MIN_BUSY));

    // R9
    poll_status_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_stb) |=> ((rd_addr != $past(ld_addr)) ||
                               (rd_data == {~$past(ld_wdata[7]), $past(ld_wdata[6:0])})));
endmodule

bind eeprom_page_writer eepw_checker #(
    .ADDR_W   (ADDR_W),
    .LOAD_WIN (LOAD_WIN),
    .PROG_CYC (PROG_CYC)
) u_eepw_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_stb   (ld_stb),
    .ld_addr  (ld_addr),
    .ld_wdata (ld_wdata),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (busy)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
    localparam int AW = 10;
    localparam int LW = 16;
    localparam int PC = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_stb = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_edge = 0;
    bit finished = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    e;
        string         tag;
    } rd_item_t;
    rd_item_t sb[$];
    event rd_evt;

    eeprom_page_writer #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) i_eeprom_page_writer (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected read results, samples mid low phase
    always @(rd_evt) begin
        rd_item_t it;
        #3;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            tests++;
            if (rd_data !== it.e) begin
                fails++;
                $display("FAIL %s: read addr %0h got %02h expected %02h", it.tag, it.a, rd_data, it.e);
            end
        end
    end

    task automatic rd_expect(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        rd_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
        -> rd_evt;
        #5;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_stb = 1'b1; ld_addr = a; ld_wdata = d;
        @(negedge clk);
        ld_stb = 1'b0;
        last_edge = cyc;
    endtask

    task automatic at_cycle(input int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic chk_busy(input logic e, input string tag);
        tests++;
        if (busy !== e) begin
            fails++;
            $display("FAIL %s: busy got %0b expected %0b", tag, busy, e);
        end
    endtask

    task automatic chk_fall(input int k, input string tag);
        at_cycle(k + LW + PC - 1);
        chk_busy(1'b1, tag);
        at_cycle(k + LW + PC);
        chk_busy(1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_busy(1'b0, "R1 reset state");

        // Burst A: full page 1, data = ofs ^ 5A
        for (int i = 0; i < 64; i++) begin
            load(AW'(10'h040 + i), 8'(i) ^ 8'h5A);
            if (i == 0) chk_busy(1'b1, "R2 first load opens burst");
        end
        k = last_edge;
        rd_expect(10'h07F, {~(8'h3F ^ 8'h5A) >> 7, 7'((8'h3F ^ 8'h5A))}, "R9 poll during window");
        chk_fall(k, "R4 full page timing");
        for (int i = 0; i < 64; i++)
            rd_expect(AW'(10'h040 + i), 8'(i) ^ 8'h5A, "R5 page commit");

        // Burst C: full page 2, data = ofs ^ C3
        for (int i = 0; i < 64; i++)
            load(AW'(10'h080 + i), 8'(i) ^ 8'hC3);
        chk_fall(last_edge, "R10 second burst timing");
        rd_expect(10'h085, 8'hC6, "R10 true data page 2");

        // Burst B: partial page 1 with retrigger, stray page, ignored late load
        load(10'h043, 8'h11);
        k = last_edge;
        chk_busy(1'b1, "R2 partial burst opens");
        load(10'h085, 8'h99);
        at_cycle(k + LW - 3);
        load(10'h043, 8'h22);
        load(10'h04A, 8'h8C);
        k = last_edge;
        load(10'h095, 8'h5F);
        rd_expect(10'h04A, 8'h0C, "R9 poll inverted bit7");
        rd_expect(10'h043, 8'h59, "R3 old data before commit");
        at_cycle(k + LW + 2);
        load(10'h054, 8'h77);
        rd_expect(10'h043, 8'h59, "R3 old data during programming");
        chk_fall(k, "R6 stray load no retrigger");
        rd_expect(10'h043, 8'h22, "R8 last value wins");
        rd_expect(10'h04A, 8'h8C, "R10 true data after commit");
        rd_expect(10'h054, 8'h4E, "R7 load during programming ignored");
        rd_expect(10'h040, 8'h5A, "R8 unloaded offset kept");
        rd_expect(10'h07F, 8'h65, "R8 unloaded offset kept high");
        rd_expect(10'h085, 8'hC6, "R6 other page not written");
        rd_expect(10'h095, 8'hD6, "R6 other page not written late");

        // Reset mid-burst keeps array and drops staged byte
        load(10'h043, 8'hEE);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_busy(1'b0, "R1 reset drops burst");
        rd_expect(10'h043, 8'h22, "R1 array survives reset");
        k = cyc;
        at_cycle(k + LW + PC + 2);
        chk_busy(1'b0, "R1 no commit after reset");
        rd_expect(10'h043, 8'h22, "R1 staged byte discarded");

        // Single-byte burst: same programming time
        load(10'h0C0, 8'h3C);
        k = last_edge;
        rd_expect(10'h0C0, 8'hBC, "R9 poll with bit7 low");
        chk_fall(k, "R4 single byte timing");
        rd_expect(10'h0C0, 8'h3C, "R10 single byte committed");

        @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule